// File: doc/BRIEF.md
# One-Time Fuse Bank Program and Read Controller

This controller sits between chip-level configuration logic and a bank of one-time electrically programmed fuses that hold a chip identification word. A caller starts one of two operations. A program operation burns a single fuse, chosen by a binary index, for a timed window. A read operation captures the sense outputs of every fuse at once into an identification register. The analog sense circuits, the high-voltage switch and the fuse elements are outside this block. The sense outputs arrive as plain digital inputs, and each per-fuse enable output drives the burn switch of its fuse.

The burn window is the requested length multiplied by a fixed prescaled tick of `TICK_CYC` clock cycles. The integrator picks `LEN_MIN` and `LEN_MAX` so that every accepted length gives a burn that is strictly longer than 0.18 ms and strictly shorter than 1.0 ms at the real clock. A length outside that range, including zero, is refused. A refused request raises an error flag and burns nothing.

Control uses level pins rather than a stream: `start_i` is sampled only while `busy_o` is low, and `done_o` marks completion. The block never applies back-pressure beyond `busy_o`. A caller that holds `start_i` high across a busy period has that request dropped, not queued.

Top module: `efuse_ctrl`

## Requirements
- R1: An accepted program request (`op_prog_i`=1) with index i drives bit i of `burn_en_o`, and only that bit, for exactly `len*TICK_CYC` consecutive cycles, starting in the cycle after the start edge.
- R2: `burn_en_o` is one-hot or all zero in every cycle.
- R3: A length of zero, or any length below `LEN_MIN` or above `LEN_MAX`, is rejected. No bit of `burn_en_o` rises, `done_o` appears two edges after the start edge, and `err_o` is high in that cycle and stays high until the next accepted start.
- R4: After a burn ends, `busy_o` stays high with `burn_en_o` all zero for `GUARD` cycles before `done_o`. `GUARD` is at least 2.
- R5: A read request (`op_prog_i`=0) copies `sense_i`, bit for bit, into `fuse_id_o` at the edge after the start edge, and `done_o` is high in the cycle that follows.
- R6: `start_i` has no effect while `busy_o` is high.
- R7: `done_o` is high for exactly one cycle per completed operation, rejected programs included, and `busy_o` is low in that cycle.
- R8: `fuse_id_o` changes only when a read completes.
- R9: After reset, `burn_en_o`, `busy_o`, `done_o`, `err_o` and `fuse_id_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Operation request, sampled while idle |
| op_prog_i | input | 1 | 1 selects program, 0 selects read |
| fuse_idx_i | input | IDXW | Binary index of the fuse to burn |
| pulse_len_i | input | LENW | Burn length in ticks |
| sense_i | input | NFUSE | Digital sense outputs of the fuses |
| burn_en_o | output | NFUSE | Per-fuse burn enable, registered |
| fuse_id_o | output | NFUSE | Captured identification word |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last program request was rejected |

## Verification
Call the edge that samples the start request edge 0. A read or a rejected program raises `done_o` after edge 1. An accepted program raises `burn_en_o` after edge 0, drops it after edge `len*TICK_CYC`, and raises `done_o` after edge `len*TICK_CYC+GUARD`. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the start request until `done_o`, checks that count against these formulas, and checks the one-hot pattern of `burn_en_o` on every sample in between. It sweeps every length value and every fuse index. It also checks that `fuse_id_o` holds, and that a start issued while busy leaves no trace, by observing the ports for several cycles after `done_o`.

// File: rtl/efuse_pkg.sv
package efuse_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BURN  = 3'd1,
    ST_GUARD = 3'd2,
    ST_REJ   = 3'd3,
    ST_READ  = 3'd4
  } efuse_state_t;
endpackage

// File: rtl/efuse_onehot_dec.sv
module efuse_onehot_dec #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input  logic [IW-1:0] idx,
  output logic [N-1:0]  mask
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    assign mask[g] = (idx == IW'(g));
  end
endmodule

// File: rtl/efuse_tick.sv
module efuse_tick #(
  parameter int TICK_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYC - 1);

  logic [PW-1:0] presc_q;

  assign tick = run && (presc_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        presc_q <= '0;
    else if (!run)     presc_q <= '0;
    else if (tick)     presc_q <= '0;
    else               presc_q <= presc_q + 1'b1;
  end

  a_r1_presc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    presc_q <= LAST);
endmodule

// File: rtl/efuse_len_chk.sv
module efuse_len_chk #(
  parameter int LW      = 9,
  parameter int LEN_MIN = 91,
  parameter int LEN_MAX = 499
) (
  input  logic [LW-1:0] len,
  output logic          ok
);
  localparam logic [LW-1:0] LO = LW'(LEN_MIN);
  localparam logic [LW-1:0] HI = LW'(LEN_MAX);

  always_comb begin
    ok = (len != '0) && (len >= LO) && (len <= HI);
  end

  initial begin
    assert (LEN_MIN >= 1 && LEN_MAX >= LEN_MIN && LEN_MAX < (1 << LW))
      else $error("length window parameters out of range");
  end
endmodule

// File: rtl/efuse_seq.sv
module efuse_seq
  import efuse_pkg::*;
#(
  parameter int NFUSE    = 32,
  parameter int LENW     = 9,
  parameter int TICK_CYC = 200,
  parameter int GUARD    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op_prog,
  input  logic             len_ok,
  input  logic [LENW-1:0]  len,
  input  logic [NFUSE-1:0] sel_mask,
  input  logic             tick,
  output logic             tick_run,
  output logic [NFUSE-1:0] burn_q,
  output logic             rd_stb,
  output logic             busy,
  output logic             done_q,
  output logic             err_q
);
  localparam int GW = (GUARD > 1) ? $clog2(GUARD) : 1;
  localparam logic [GW-1:0] GLOAD = GW'(GUARD - 1);

  efuse_state_t  st_q;
  logic [LENW-1:0] ticks_q;
  logic [GW-1:0]   gcnt_q;
  logic            accept;

  assign busy     = (st_q != ST_IDLE);
  assign accept   = start && !busy;
  assign tick_run = (st_q == ST_BURN);
  assign rd_stb   = (st_q == ST_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ticks_q <= '0;
      gcnt_q  <= '0;
      burn_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          err_q <= 1'b0;
          if (!op_prog)    st_q <= ST_READ;
          else if (len_ok) begin
            st_q    <= ST_BURN;
            burn_q  <= sel_mask;
            ticks_q <= len;
          end else         st_q <= ST_REJ;
        end
        ST_BURN: if (tick) begin
          if (ticks_q == LENW'(1)) begin
            burn_q <= '0;
            gcnt_q <= GLOAD;
            st_q   <= ST_GUARD;
          end else begin
            ticks_q <= ticks_q - 1'b1;
          end
        end
        ST_GUARD: begin
          if (gcnt_q == '0) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            gcnt_q <= gcnt_q - 1'b1;
          end
        end
        ST_REJ: begin
          err_q  <= 1'b1;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        ST_READ: begin
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  initial begin
    assert (GUARD >= 2) else $error("GUARD must be at least 2");
  end

  // burn length checker: counts enable cycles against requested length
  logic [LENW-1:0] chk_len_q;
  logic [31:0]     chk_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_len_q <= '0;
      chk_cnt_q <= '0;
    end else begin
      if (accept) chk_len_q <= len;
      if (|burn_q) chk_cnt_q <= chk_cnt_q + 1;
      else         chk_cnt_q <= '0;
    end
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(burn_q));
  a_r1_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|burn_q) |-> chk_cnt_q == 32'(chk_len_q) * 32'(TICK_CYC));
  a_r4_guard_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|burn_q) |=> (burn_q == '0) && busy);
  a_r3_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REJ) |-> (burn_q == '0));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);
  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BURN) && !tick |=> (st_q == ST_BURN));
endmodule

// File: rtl/efuse_ctrl.sv
module efuse_ctrl #(
  parameter int NFUSE    = 32,
  parameter int LENW     = 9,
  parameter int TICK_CYC = 200,
  parameter int LEN_MIN  = 91,
  parameter int LEN_MAX  = 499,
  parameter int GUARD    = 2,
  parameter int IDXW     = $clog2(NFUSE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             op_prog_i,
  input  logic [IDXW-1:0]  fuse_idx_i,
  input  logic [LENW-1:0]  pulse_len_i,
  input  logic [NFUSE-1:0] sense_i,
  output logic [NFUSE-1:0] burn_en_o,
  output logic [NFUSE-1:0] fuse_id_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  logic [NFUSE-1:0] sel_mask;
  logic             len_ok;
  logic             tick;
  logic             tick_run;
  logic             rd_stb;
  logic [NFUSE-1:0] id_q;

  efuse_onehot_dec #(.N(NFUSE), .IW(IDXW)) u_dec (
    .idx  (fuse_idx_i),
    .mask (sel_mask)
  );

  efuse_len_chk #(.LW(LENW), .LEN_MIN(LEN_MIN), .LEN_MAX(LEN_MAX)) u_chk (
    .len (pulse_len_i),
    .ok  (len_ok)
  );

  efuse_tick #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (tick_run),
    .tick  (tick)
  );

  efuse_seq #(
    .NFUSE(NFUSE), .LENW(LENW), .TICK_CYC(TICK_CYC), .GUARD(GUARD)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_i),
    .op_prog  (op_prog_i),
    .len_ok   (len_ok),
    .len      (pulse_len_i),
    .sel_mask (sel_mask),
    .tick     (tick),
    .tick_run (tick_run),
    .burn_q   (burn_en_o),
    .rd_stb   (rd_stb),
    .busy     (busy_o),
    .done_q   (done_o),
    .err_q    (err_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      id_q <= '0;
    else if (rd_stb) id_q <= sense_i;
  end

  assign fuse_id_o = id_q;

  a_r8_id_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fuse_id_o) |-> done_o);
  a_r2_no_burn_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> (burn_en_o == '0));
endmodule

// File: tb/sim_efuse_ctrl.sv
module sim_efuse_ctrl;
  localparam int NF = 32;
  localparam int LW = 9;
  localparam int T  = 3;
  localparam int LMIN = 5;
  localparam int LMAX = 12;
  localparam int G  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic op_prog = 1'b0;
  logic [4:0] idx = '0;
  logic [LW-1:0] len = '0;
  logic [NF-1:0] sense = '0;
  logic [NF-1:0] burn_en, fuse_id;
  logic busy, done, err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  efuse_ctrl #(.NFUSE(NF), .LENW(LW), .TICK_CYC(T), .LEN_MIN(LMIN),
               .LEN_MAX(LMAX), .GUARD(G)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_prog_i(op_prog),
    .fuse_idx_i(idx), .pulse_len_i(len), .sense_i(sense),
    .burn_en_o(burn_en), .fuse_id_o(fuse_id), .busy_o(busy),
    .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // program op; optional stray start during busy (R6)
  task automatic do_prog(input int i, input int l, input bit stray);
    int n, bcnt, bad;
    bit valid;
    logic [NF-1:0] id_before;
    valid = (l >= LMIN) && (l <= LMAX);
    id_before = fuse_id;
    @(negedge clk);
    start = 1'b1; op_prog = 1'b1; idx = 5'(i); len = LW'(l);
    @(negedge clk);
    start = 1'b0;
    n = 1; bcnt = 0; bad = 0;
    while (!done && n < 5000) begin
      if (burn_en != 0) begin
        bcnt++;
        if (burn_en != (NF'(1) << i)) bad++;
      end
      if (stray && n == 2) begin
        start = 1'b1; op_prog = 1'b0; sense = ~sense;
      end else if (stray && n == 3) begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    chk(n == (valid ? l*T + G + 1 : 2), valid ? "R1/R4 done cycle" : "R3 done cycle",
        n, valid ? l*T + G + 1 : 2);
    chk(bcnt == (valid ? l*T : 0), valid ? "R1 burn length" : "R3 no burn", bcnt, valid ? l*T : 0);
    chk(bad == 0, "R2 one-hot pattern", bad, 0);
    chk(err == !valid, "R3 error flag", err, !valid);
    chk(!busy, "R7 idle at done", busy, 0);
    @(negedge clk);
    chk(!done, "R7 single done", done, 0);
    chk(fuse_id == id_before, "R8 id held over program", fuse_id, id_before);
    if (stray) begin
      repeat (4) begin
        chk(!busy && !done && burn_en == 0, "R6 stray start ignored", {busy, done}, 0);
        @(negedge clk);
      end
      chk(fuse_id == id_before, "R6 stray read dropped", fuse_id, id_before);
    end
  endtask

  task automatic do_read(input logic [NF-1:0] v);
    int n;
    @(negedge clk);
    sense = v; start = 1'b1; op_prog = 1'b0;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n == 2, "R5 read latency", n, 2);
    chk(fuse_id == v, "R5 read value", fuse_id, v);
    chk(burn_en == 0, "R2 no burn in read", burn_en, 0);
    sense = ~v;
    repeat (3) @(negedge clk);
    chk(fuse_id == v, "R8 id held", fuse_id, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(burn_en == 0 && !busy && !done && !err && fuse_id == 0, "R9 reset state",
        {burn_en, busy, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(burn_en == 0 && fuse_id == 0, "R9 after release", burn_en, 0);
    do_read(32'hA5C3_0F81);
    do_read(32'h0000_0000);
    do_read(32'hFFFF_FFFF);
    for (int i = 0; i < NF; i++) do_prog(i, LMIN + (i % (LMAX - LMIN + 1)), 1'b0);
    for (int l = 0; l < (1 << LW); l++) do_prog(l % NF, l, 1'b0);
    do_prog(7, 0, 1'b0);
    do_read(32'h1234_5678);
    chk(!err, "R3 error cleared by next start", err, 0);
    do_prog(3, LMIN, 1'b1);
    do_prog(31, LMAX, 1'b1);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule